// File: doc/BRIEF.md
# Hourly Chime Tone Generator

This block turns the minute and second readings of a running time-of-day counter into a single audio line that marks the top of every hour. It makes two square-wave tones from the system clock. Both come from free-running dividers, so no derived clock is needed. Near the end of each hour it sounds a short countdown of low-pitched beeps. At the hour itself it sounds one beep in a higher pitch.

The countdown beeps fall on minute 59, seconds 55, 57 and 59. The hour beep falls on minute 00, second 00. Each beep lasts for the whole second in which that time is shown. At every other moment the line rests high, and it also rests high when the chime enable is low. The clock counting, loudness control and speaker drive are outside this block.

Minute and second arrive as packed BCD: the tens digit is in bits [7:4] and the units digit is in bits [3:0]. There is no data stream, so every pin is a plain level. A change on a time input reaches the output in the same cycle.

Top module: `chime_tone_gen`

## Requirements
- R1: With `chime_en` high and `min_bcd` = 8'h59, `sec_bcd` equal to 8'h55, 8'h57 or 8'h59 makes `chime_o` follow the low tone.
- R2: With `chime_en` high, `min_bcd` = 8'h00 and `sec_bcd` = 8'h00 make `chime_o` follow the high tone.
- R3: With `chime_en` high, every other minute/second pair drives `chime_o` to 1. This includes 59:54, 59:56, 59:58, 00:01 and 58:55.
- R4: With `chime_en` low, `chime_o` is 1 for every time value.
- R5: The high tone is a 50% square wave with a period of 2*HALF_HI clocks. It is 1 for the first HALF_HI clocks after reset is released.
- R6: The low tone has twice the period of the high tone, at 50% duty. It changes only in the cycle in which the high tone rises, and it starts at 1 after reset.
- R7: While `rst_n` is low, `chime_o` is 1. Releasing reset restarts both tones from their initial phase.
- R8: `chime_o` reacts to a change of `min_bcd`, `sec_bcd` or `chime_en` in the same cycle, so each beep spans exactly the interval in which the matching time is present.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| chime_en | input | 1 | Enables the chime when high |
| min_bcd | input | 8 | Current minute, packed BCD |
| sec_bcd | input | 8 | Current second, packed BCD |
| chime_o | output | 1 | Tone line, rests high |

## Verification
The bench walks through the seconds on either side of each beep: 59:54, 59:56, 59:58, 00:01, and 58:55, which has the right second but the wrong minute. A decoder that matches only the second, or that beeps on every second from 55 onward, fails here with a tone where a steady 1 belongs.

Tone phase is compared on every clock against counts derived from the time since reset. A divider with an off-by-one period, or a low tone that toggles on the falling edge of the high tone, drifts from the model within a few periods.

Enable-low and mid-run reset cases catch a design that ignores `chime_en` or keeps its divider phase through reset.

// File: rtl/chime_pkg.sv
package chime_pkg;
  typedef enum logic [1:0] {
    SLOT_QUIET     = 2'd0,
    SLOT_COUNTDOWN = 2'd1,
    SLOT_HOUR      = 2'd2
  } chime_slot_e;

  localparam int          NUM_CD_SECS        = 3;
  localparam logic [7:0]  CD_MINUTE          = 8'h59;
  localparam logic [7:0]  CD_SECS [NUM_CD_SECS] = '{8'h55, 8'h57, 8'h59};
  localparam logic [7:0]  HOUR_MINUTE        = 8'h00;
  localparam logic [7:0]  HOUR_SECOND        = 8'h00;
endpackage

// File: rtl/chime_tone_div.sv
module chime_tone_div #(
  parameter int HALF_HI = 12500
) (
  input  logic clk,
  input  logic rst_n,
  output logic hi_tone_o,
  output logic lo_tone_o
);
  localparam int CW = (HALF_HI > 1) ? $clog2(HALF_HI) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_HI - 1);

  logic [CW-1:0] cnt_q;
  logic          hi_q, lo_q;
  logic          wrap;

  assign wrap = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      hi_q  <= 1'b1;
      lo_q  <= 1'b1;
    end else begin
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      if (wrap) hi_q <= ~hi_q;
      if (wrap && !hi_q) lo_q <= ~lo_q;
    end
  end

  assign hi_tone_o = hi_q;
  assign lo_tone_o = lo_q;

  // R6: low tone moves only together with a rising high tone
  a_r6_lo_on_hi_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lo_q) |-> $rose(hi_q));
  // R5: high tone holds steady except at the wrap of the half-period count
  a_r5_hi_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> $stable(hi_q));
endmodule

// File: rtl/chime_slot_decode.sv
module chime_slot_decode
  import chime_pkg::*;
(
  input  logic [7:0]  min_bcd,
  input  logic [7:0]  sec_bcd,
  output chime_slot_e slot_o
);
  logic [NUM_CD_SECS-1:0] sec_hit;

  for (genvar g = 0; g < NUM_CD_SECS; g++) begin : g_cd
    assign sec_hit[g] = (sec_bcd == CD_SECS[g]);
  end

  always_comb begin
    slot_o = SLOT_QUIET;
    if (min_bcd == CD_MINUTE && |sec_hit)
      slot_o = SLOT_COUNTDOWN;
    else if (min_bcd == HOUR_MINUTE && sec_bcd == HOUR_SECOND)
      slot_o = SLOT_HOUR;
  end
endmodule

// File: rtl/chime_tone_gen.sv
module chime_tone_gen
  import chime_pkg::*;
#(
  parameter int HALF_HI = 12500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chime_en,
  input  logic [7:0] min_bcd,
  input  logic [7:0] sec_bcd,
  output logic       chime_o
);
  logic        hi_tone, lo_tone;
  chime_slot_e slot;

  chime_tone_div #(.HALF_HI(HALF_HI)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .hi_tone_o (hi_tone),
    .lo_tone_o (lo_tone)
  );

  chime_slot_decode u_dec (
    .min_bcd (min_bcd),
    .sec_bcd (sec_bcd),
    .slot_o  (slot)
  );

  always_comb begin
    chime_o = 1'b1;
    if (rst_n && chime_en) begin
      case (slot)
        SLOT_COUNTDOWN: chime_o = lo_tone;
        SLOT_HOUR:      chime_o = hi_tone;
        default:        chime_o = 1'b1;
      endcase
    end
  end

  // R4: disabled chime keeps the line high
  a_r4_disabled_high: assert property (@(posedge clk) disable iff (!rst_n)
    !chime_en |-> chime_o);
  // R1: countdown second at minute 59 carries the low tone
  a_r1_countdown_low: assert property (@(posedge clk) disable iff (!rst_n)
    (chime_en && min_bcd == 8'h59 && sec_bcd == 8'h57) |-> (chime_o == lo_tone));
  // R2: the hour mark carries the high tone
  a_r2_hour_high: assert property (@(posedge clk) disable iff (!rst_n)
    (chime_en && min_bcd == 8'h00 && sec_bcd == 8'h00) |-> (chime_o == hi_tone));
  // R3: a second between countdown beeps stays quiet
  a_r3_gap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (min_bcd == 8'h59 && (sec_bcd == 8'h56 || sec_bcd == 8'h58)) |-> chime_o);
  // R7: line is high during reset
  a_r7_reset_high: assert property (@(posedge clk)
    !rst_n |-> chime_o);
endmodule

// File: tb/test_chime_tone_gen.sv
module test_chime_tone_gen;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;
  localparam int HOLD       = 37;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       chime_en = 1'b0;
  logic [7:0] min_bcd = 8'h00;
  logic [7:0] sec_bcd = 8'h00;
  logic       chime_o;

  int checks = 0;
  int fails  = 0;
  int n_edges = 0;
  bit done = 1'b0;

  chime_tone_gen #(.HALF_HI(HALF)) i_chime_tone_gen (
    .clk(clk), .rst_n(rst_n), .chime_en(chime_en),
    .min_bcd(min_bcd), .sec_bcd(sec_bcd), .chime_o(chime_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // edges seen with reset released
  always @(posedge clk) begin
    if (!rst_n) n_edges <= 0;
    else        n_edges <= n_edges + 1;
  end

  function automatic bit model_hi(int n);
    return ((n / HALF) % 2) == 0;
  endfunction
  function automatic bit model_lo(int n);
    return ((n / (2*HALF)) % 2) == 0;
  endfunction

  // compare on every falling edge
  always @(negedge clk) begin
    bit    exp_v;
    string req;
    if (!done) begin
      if (!rst_n) begin
        exp_v = 1'b1; req = "R7";
      end else if (!chime_en) begin
        exp_v = 1'b1; req = "R4";
      end else if (min_bcd == 8'h59 &&
                   (sec_bcd == 8'h55 || sec_bcd == 8'h57 || sec_bcd == 8'h59)) begin
        exp_v = model_lo(n_edges); req = "R1/R6/R8";
      end else if (min_bcd == 8'h00 && sec_bcd == 8'h00) begin
        exp_v = model_hi(n_edges); req = "R2/R5/R8";
      end else begin
        exp_v = 1'b1; req = "R3";
      end
      checks++;
      if (chime_o !== exp_v) begin
        fails++;
        $display("FAIL %s at %0t: min=%h sec=%h en=%b actual=%b expected=%b",
                 req, $time, min_bcd, sec_bcd, chime_en, chime_o, exp_v);
      end
    end
  end

  task automatic show(input logic [7:0] m, input logic [7:0] s, input logic en);
    @(negedge clk);
    #1;
    min_bcd = m; sec_bcd = s; chime_en = en;
    repeat (HOLD) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    // R5 R2: hour tone from the first cycle after reset
    show(8'h00, 8'h00, 1'b1);
    // R3 neighbours and R1 countdown
    show(8'h58, 8'h59, 1'b1);
    show(8'h59, 8'h54, 1'b1);
    show(8'h59, 8'h55, 1'b1);
    show(8'h59, 8'h56, 1'b1);
    show(8'h59, 8'h57, 1'b1);
    show(8'h59, 8'h58, 1'b1);
    show(8'h59, 8'h59, 1'b1);
    show(8'h00, 8'h00, 1'b1);
    show(8'h00, 8'h01, 1'b1);
    show(8'h58, 8'h55, 1'b1);
    show(8'h12, 8'h34, 1'b1);
    // R4 disabled over beep slots
    show(8'h59, 8'h57, 1'b0);
    show(8'h00, 8'h00, 1'b0);
    // R8 fast changes
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); #1;
      min_bcd = (i % 2) ? 8'h59 : 8'h00;
      sec_bcd = (i % 2) ? 8'h59 : 8'h00;
      chime_en = (i % 5) != 4;
    end
    // R7 reset mid-run restarts phase
    show(8'h59, 8'h55, 1'b1);
    @(negedge clk); #1 rst_n = 1'b0;
    repeat (5) @(negedge clk);
    #1 rst_n = 1'b1;
    show(8'h00, 8'h00, 1'b1);
    show(8'h59, 8'h59, 1'b1);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule